// File: doc/BRIEF.md
# Calibration Trigger Gate

This block decides, on every bunch-crossing clock, whether a calibration trigger accept may go out. Up to sixteen sub-detector sources each present a 3-bit request code. The machine turns are shared between the sources in rotation. A 4-bit turn index advances on every turn-start strobe, and the source whose number equals that index owns the turn. An accept is issued only for that owner. It is issued only in a bunch slot marked in a programmable calibration bunch mask, and only while neither internal dead-time nor an external busy is present.

With each accept the block presents a trigger-type word. Downstream logic uses this word to tell which source fired and with which code. The bunch mask has one bit per bunch slot of the turn. It is loaded through a simple write port (enable, address, one data bit) and can mark, for example, empty bunches or a long gap.

Top module: `calib_gate`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `accept` and `ttype` to 0, sets the turn index to 0 and clears every bit of the bunch mask. With the mask clear, no accept is issued for any request.
- R2: Each cycle with `turn_start` high advances the turn index by one, wrapping from 15 to 0. The new index already owns the strobe cycle itself, which is bunch 0 of the new turn.
- R3: Only the source whose number equals the current turn index can cause an accept. Requests on every other source have no effect on `accept` or `ttype`.
- R4: A request code of 0 means no request and never causes an accept. Codes 1 to 7 are requests.
- R5: An accept needs the mask bit at the current `bcid` to be 1. A write (`mask_we` high) stores `mask_wdata` at `mask_addr` and takes effect from the next cycle on.
- R6: No accept is issued for a cycle in which `dead_time` is high.
- R7: No accept is issued for a cycle in which `ext_busy` is high.
- R8: `accept` and `ttype` are registered. They are valid in the cycle after the inputs that caused them, and at most one accept occurs per clock. With an accept, `ttype` is {bit 7 = 1, bits 6:3 = turn index, bits 2:0 = request code}. Without one, `ttype` is 0.
- R9: A `bcid` of 3564 or above never yields an accept. A write to `mask_addr` 3564 or above is ignored and changes no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| turn_start | input | 1 | Strobe at bunch 0 of each new turn |
| bcid | input | 12 | Current bunch-crossing number |
| req_flat | input | 48 | Request codes, source i at bits [3i+2:3i] |
| dead_time | input | 1 | Internal dead-time, blocks accepts |
| ext_busy | input | 1 | External busy, blocks accepts |
| mask_we | input | 1 | Bunch-mask write enable |
| mask_addr | input | 12 | Bunch-mask write address |
| mask_wdata | input | 1 | Bunch-mask write data |
| accept | output | 1 | Calibration accept pulse |
| ttype | output | 8 | Trigger-type word for the accept |

## Verification
Each decision is due exactly one clock after the request, `bcid`, busy and turn inputs that produced it. A mask write or a turn strobe needs one cycle of its own before it affects a later decision. The bench drives inputs 1 ns after a rising edge and compares `accept` and `ttype` 1 ns after the next rising edge, so each comparison sees the result of exactly one set of inputs. Mask writes and strobes are applied as separate cycles ahead of the probing cycle, and the bench keeps its own turn count to form the expected `ttype`.

// File: rtl/calib_pkg.sv
package calib_pkg;
    localparam int REQ_W  = 3;
    localparam int TURNS  = 16;
    localparam int TURN_W = $clog2(TURNS);
    localparam int TT_W   = 1 + TURN_W + REQ_W;

    typedef struct packed {
        logic            accept;
        logic [TT_W-1:0] ttype;
    } grant_t;
endpackage

// File: rtl/calib_turn_ctr.sv
module calib_turn_ctr
    import calib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [TURN_W-1:0] turn_q,
    output logic [TURN_W-1:0] turn_cur
);
    localparam logic [TURN_W-1:0] LAST = TURN_W'(TURNS - 1);

    logic [TURN_W-1:0] turn_d;
    logic [TURN_W-1:0] turn_r;
    logic [TURN_W-1:0] turn_inc;

    always_comb begin
        turn_inc = (turn_r == LAST) ? '0 : turn_r + 1'b1;
        turn_d   = step ? turn_inc : turn_r;
        // the strobe cycle is bunch 0 of the new turn
        turn_cur = turn_d;
    end

    always_ff @(posedge clk) begin
        if (rst) turn_r <= '0;
        else     turn_r <= turn_d;
    end

    assign turn_q = turn_r;
endmodule

// File: rtl/calib_bx_mask.sv
module calib_bx_mask #(
    parameter int DEPTH = 3564,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          hit
);
    localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

    logic [DEPTH-1:0] mask_d;
    logic [DEPTH-1:0] mask_q;

    always_comb begin
        mask_d = mask_q;
        if (we && (waddr < LIMIT)) mask_d[waddr] = wdata;
        hit = (raddr < LIMIT) ? mask_q[raddr] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/calib_grant.sv
module calib_grant
    import calib_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TURN_W-1:0]        turn,
    input  logic [NUM_SRC*REQ_W-1:0] req_flat,
    input  logic                     hit,
    input  logic                     dead_time,
    input  logic                     ext_busy,
    output logic                     accept,
    output logic [TT_W-1:0]          ttype
);
    logic [REQ_W-1:0] code;
    logic             fire;
    grant_t           g_d;
    grant_t           g_q;

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (turn == TURN_W'(i)) code = req_flat[i*REQ_W +: REQ_W];
        end
        fire     = (code != '0) && hit && !dead_time && !ext_busy;
        g_d      = '0;
        g_d.accept = fire;
        if (fire) g_d.ttype = {1'b1, turn, code};
    end

    always_ff @(posedge clk) begin
        if (rst) g_q <= '0;
        else     g_q <= g_d;
    end

    assign accept = g_q.accept;
    assign ttype  = g_q.ttype;
endmodule

// File: rtl/calib_gate.sv
module calib_gate
    import calib_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int BX_N    = 3564,
    parameter int BX_W    = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     turn_start,
    input  logic [BX_W-1:0]          bcid,
    input  logic [NUM_SRC*REQ_W-1:0] req_flat,
    input  logic                     dead_time,
    input  logic                     ext_busy,
    input  logic                     mask_we,
    input  logic [BX_W-1:0]          mask_addr,
    input  logic                     mask_wdata,
    output logic                     accept,
    output logic [TT_W-1:0]          ttype
);
    logic [TURN_W-1:0] turn_q_w;
    logic [TURN_W-1:0] turn_cur_w;
    logic              mask_hit_w;

    calib_turn_ctr i_turn (
        .clk      (clk),
        .rst      (rst),
        .step     (turn_start),
        .turn_q   (turn_q_w),
        .turn_cur (turn_cur_w)
    );

    calib_bx_mask #(.DEPTH(BX_N), .AW(BX_W)) i_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we),
        .waddr (mask_addr),
        .wdata (mask_wdata),
        .raddr (bcid),
        .hit   (mask_hit_w)
    );

    calib_grant #(.NUM_SRC(NUM_SRC)) i_grant (
        .clk       (clk),
        .rst       (rst),
        .turn      (turn_cur_w),
        .req_flat  (req_flat),
        .hit       (mask_hit_w),
        .dead_time (dead_time),
        .ext_busy  (ext_busy),
        .accept    (accept),
        .ttype     (ttype)
    );
endmodule

// File: rtl/calib_gate_chk.sv
module calib_gate_chk
    import calib_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              turn_start,
    input logic              dead_time,
    input logic              ext_busy,
    input logic              accept,
    input logic [TT_W-1:0]   ttype,
    input logic [TURN_W-1:0] turn_q,
    input logic [TURN_W-1:0] turn_cur,
    input logic              hit
);
    localparam logic [TURN_W-1:0] LAST = TURN_W'(TURNS - 1);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!accept && ttype == '0 && turn_q == '0));

    p_turn_step_r2: assert property (@(posedge clk) disable iff (rst)
        turn_start |=> turn_q == (($past(turn_q) == LAST) ? '0 : $past(turn_q) + 1'b1));

    p_code_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        accept |-> ttype[REQ_W-1:0] != '0);

    p_mask_needed_r5: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !accept);

    p_dead_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        dead_time |=> !accept);

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        ext_busy |=> !accept);

    p_ttype_turn_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && accept |-> (ttype[TT_W-1] && ttype[TT_W-2:REQ_W] == $past(turn_cur)));

    p_ttype_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !accept |-> ttype == '0);
endmodule

bind calib_gate calib_gate_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .turn_start (turn_start),
    .dead_time  (dead_time),
    .ext_busy   (ext_busy),
    .accept     (accept),
    .ttype      (ttype),
    .turn_q     (turn_q_w),
    .turn_cur   (turn_cur_w),
    .hit        (mask_hit_w)
);

// File: tb/test_calib_gate.sv
`timescale 1ns/1ps
module test_calib_gate;
    logic        clk = 1'b0;
    logic        rst;
    logic        turn_start;
    logic [11:0] bcid;
    logic [47:0] req_flat;
    logic        dead_time;
    logic        ext_busy;
    logic        mask_we;
    logic [11:0] mask_addr;
    logic        mask_wdata;
    logic        accept;
    logic [7:0]  ttype;

    int n_chk  = 0;
    int n_fail = 0;
    int tb_turn = 0;

    always #4 clk = ~clk;

    calib_gate i_calib_gate (
        .clk(clk), .rst(rst), .turn_start(turn_start), .bcid(bcid),
        .req_flat(req_flat), .dead_time(dead_time), .ext_busy(ext_busy),
        .mask_we(mask_we), .mask_addr(mask_addr), .mask_wdata(mask_wdata),
        .accept(accept), .ttype(ttype)
    );

    task automatic check(string tag, logic exp_acc, logic [7:0] exp_tt);
        n_chk++;
        if (accept !== exp_acc || ttype !== exp_tt) begin
            n_fail++;
            $display("FAIL %s: accept=%0b ttype=%02h expected accept=%0b ttype=%02h",
                     tag, accept, ttype, exp_acc, exp_tt);
        end
    endtask

    function automatic logic [7:0] tt(int turn, int code);
        return {1'b1, 4'(turn), 3'(code)};
    endfunction

    task automatic set_req(int src, int code);
        req_flat[src*3 +: 3] = 3'(code);
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic write_mask(int addr, logic val);
        mask_we = 1'b1; mask_addr = 12'(addr); mask_wdata = val;
        tick();
        mask_we = 1'b0;
    endtask

    task automatic strobe;
        turn_start = 1'b1; bcid = 12'd0;
        tick();
        turn_start = 1'b0;
        tb_turn = (tb_turn + 1) % 16;
    endtask

    // drive one bunch slot, then compare the registered result
    task automatic probe(string tag, int bx, logic exp_acc, int code);
        bcid = 12'(bx);
        tick();
        check(tag, exp_acc, exp_acc ? tt(tb_turn, code) : 8'h00);
    endtask

    task automatic do_reset;
        rst = 1'b1; tick(); tick(); rst = 1'b0; tb_turn = 0;
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 outputs after reset", 1'b0, 8'h00);
        for (int s = 0; s < 16; s++) set_req(s, 7);
        probe("R1 mask clear, no accept", 100, 1'b0, 0);
        probe("R1 mask clear at bunch 0", 0, 1'b0, 0);
        req_flat = '0;
    endtask

    task automatic t_basic;
        write_mask(100, 1'b1);
        set_req(0, 5);
        probe("R8 accept turn 0 code 5", 100, 1'b1, 5);
        probe("R5 unmasked slot 101", 101, 1'b0, 0);
        probe("R8 accept again next masked probe", 100, 1'b1, 5);
    endtask

    task automatic t_owner;
        set_req(0, 0); set_req(3, 7);
        probe("R4 owner code 0", 100, 1'b0, 0);
        probe("R3 non-owner source 3 ignored", 100, 1'b0, 0);
    endtask

    task automatic t_advance;
        strobe(); strobe(); strobe();
        probe("R2 turn 3 owns after three strobes", 100, 1'b1, 7);
        set_req(3, 0);
    endtask

    task automatic t_strobe_cycle;
        write_mask(0, 1'b1);
        set_req(4, 2);
        turn_start = 1'b1; bcid = 12'd0;
        tb_turn = 4;
        tick();
        turn_start = 1'b0;
        check("R2 strobe cycle owned by new turn", 1'b1, tt(4, 2));
        write_mask(0, 1'b0);
        probe("R5 cleared bit 0", 0, 1'b0, 0);
        set_req(4, 0);
    endtask

    task automatic t_mask;
        set_req(tb_turn, 6);
        probe("R5 slot 200 not yet set", 200, 1'b0, 0);
        write_mask(200, 1'b1);
        probe("R5 slot 200 after write", 200, 1'b1, 6);
        write_mask(200, 1'b0);
        probe("R5 slot 200 after clear", 200, 1'b0, 0);
        write_mask(3563, 1'b1);
        probe("R5 last slot 3563", 3563, 1'b1, 6);
    endtask

    task automatic t_blocks;
        dead_time = 1'b1;
        probe("R6 dead-time blocks", 100, 1'b0, 0);
        dead_time = 1'b0; ext_busy = 1'b1;
        probe("R7 external busy blocks", 100, 1'b0, 0);
        ext_busy = 1'b0;
        probe("R6 R7 released", 100, 1'b1, 6);
    endtask

    task automatic t_range;
        probe("R9 bcid 3564 out of range", 3564, 1'b0, 0);
        probe("R9 bcid 4095 out of range", 4095, 1'b0, 0);
        write_mask(4000, 1'b1);
        probe("R9 write to 4000 leaves 436 clear", 436, 1'b0, 0);
        set_req(tb_turn, 0);
    endtask

    task automatic t_wrap;
        for (int s = 0; s < 16; s++) set_req(s, (s % 7) + 1);
        while (tb_turn != 15) strobe();
        probe("R2 turn 15", 100, 1'b1, 2);
        strobe();
        probe("R2 wrap to turn 0", 100, 1'b1, 1);
        strobe();
        probe("R2 turn 1 after wrap", 100, 1'b1, 2);
    endtask

    task automatic t_reset_midrun;
        strobe(); strobe();
        do_reset();
        check("R1 mid-run reset outputs", 1'b0, 8'h00);
        probe("R1 mid-run reset clears mask", 100, 1'b0, 0);
        write_mask(100, 1'b1);
        probe("R1 turn back to 0", 100, 1'b1, 1);
    endtask

    initial begin
        rst = 1'b1; turn_start = 1'b0; bcid = '0; req_flat = '0;
        dead_time = 1'b0; ext_busy = 1'b0;
        mask_we = 1'b0; mask_addr = '0; mask_wdata = 1'b0;
        t_reset();
        t_basic();
        t_owner();
        t_advance();
        t_strobe_cycle();
        t_mask();
        t_blocks();
        t_range();
        t_wrap();
        t_reset_midrun();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule